// File: doc/BRIEF.md
# Load Permission Gate with Result Masking

This block is one stage of a load port. Each load arrives with its virtual page number, the privilege level it runs at, the raw data the memory side returned and a reorder tag. The stage searches a small fully-associative translation cache that keeps only page permission bits. When no entry matches, the stage holds the load, raises a page-walk request and waits for the walker to answer through a fill interface. When an entry matches, the load finishes in the next cycle.

A permission problem never holds the pipe or raises an early trap. The result still comes out on the normal schedule, but it carries a fault-at-retire flag and its data is forced to zero. Younger dependent work can therefore keep running without ever seeing the protected value. The reorder buffer raises the real fault when the tagged load retires. A flush input discards a load that is waiting on a walk.

Top module: `ld_perm_gate`

## Requirements
- R1: After reset, res_valid and walk_req are 0, req_ready is 1, and the translation cache holds no entries, so the first load to any page misses.
- R2: A load that is accepted (req_valid and req_ready high, flush low) and matches no entry drives walk_req to 1 and walk_vpn to its page in the next cycle. It drops req_ready and produces no result until a fill or a flush arrives.
- R3: A fill_valid pulse during a walk completes the waiting load in the next cycle with its own tag. It also installs the page with the filled user and present bits, so a later load to the same page matches without a walk.
- R4: A load that matches an entry and is allowed produces res_valid exactly one cycle after acceptance, with res_data equal to req_data, res_fault 0 and the load's tag.
- R5: A user-mode load (req_user=1) that matches an entry whose user bit is 0 still completes one cycle after acceptance with no walk and no stall, with res_fault 1 and res_data 0.
- R6: A supervisor-mode load (req_user=0) to a present entry passes whatever that entry's user bit is.
- R7: A walk answer with fill_present=0 (no mapping) completes the load with res_fault 1 and res_data 0. Later loads that match that entry fault the same way with no walk.
- R8: The cache has 8 entries and replaces them in round-robin order in the order of fills. The ninth distinct page filled after reset evicts the first one, and the tenth evicts the second.
- R9: A flush during a walk cancels the waiting load. No result appears for it, walk_req falls and req_ready rises in the next cycle, and a later fill_valid while idle is ignored and installs nothing. A request presented in a cycle with flush high is not accepted.
- R10: res_valid is a one-cycle pulse per completed load, and a result with res_fault 1 always has res_data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Stage can take a load (low while walking) |
| req_vpn | input | 20 | Virtual page number of the load |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| req_data | input | 64 | Raw data returned for the load |
| req_tag | input | 6 | Reorder tag of the load |
| flush | input | 1 | Cancel a waiting load; blocks acceptance this cycle |
| walk_req | output | 1 | Page walk requested |
| walk_vpn | output | 20 | Page to walk |
| fill_valid | input | 1 | Walk answer present |
| fill_user | input | 1 | Walked page is user accessible |
| fill_present | input | 1 | Walked page has a mapping |
| res_valid | output | 1 | Result strobe |
| res_data | output | 64 | Result data (zero when faulted) |
| res_fault | output | 1 | Fault at retirement |
| res_tag | output | 6 | Reorder tag of the result |

## Verification
The hardest case to reach from the ports is eviction order. Proving that the ninth and tenth distinct fills replace exactly the oldest entries requires filling every slot first, then confirming by hits that survivors remain and by walk requests that victims are gone. The stimulus also places a flushed walk inside that sequence, so a cancelled fill must not use up a slot. The check is that the slot pattern still lines up with the round-robin count. Permission outcomes are driven by choosing the fill bits and then reusing the same pages at both privilege levels.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } lpg_state_e;

  // Access is refused when the page has no mapping, or a user load hits a
  // supervisor-only page.
  function automatic logic lpg_denied(input logic is_user,
                                      input logic pg_user,
                                      input logic pg_present);
    return !pg_present || (is_user && !pg_user);
  endfunction

endpackage

// File: rtl/lpg_tlb.sv
module lpg_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic             lk_user,
  output logic             lk_present,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic             fill_user,
  input  logic             fill_present
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic             ent_valid   [ENTRIES];
  logic             ent_user    [ENTRIES];
  logic             ent_present [ENTRIES];
  logic [VPN_W-1:0] ent_vpn     [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [PTR_W-1:0] rr_ptr;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic sel;
      assign sel = fill_en && (rr_ptr == PTR_W'(g));

      always_ff @(posedge clk) begin
        if (rst)      ent_valid[g] <= 1'b0;
        else if (sel) ent_valid[g] <= 1'b1;
      end

      always_ff @(posedge clk) begin
        if (sel) begin
          ent_vpn[g]     <= fill_vpn;
          ent_user[g]    <= fill_user;
          ent_present[g] <= fill_present;
        end
      end

      assign match[g] = ent_valid[g] && (ent_vpn[g] == lk_vpn);
    end
  endgenerate

  always_comb begin
    lk_user    = 1'b0;
    lk_present = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_user    = lk_user    | (match[i] & ent_user[i]);
      lk_present = lk_present | (match[i] & ent_present[i]);
    end
  end

  assign lk_hit = |match;

  always_ff @(posedge clk) begin
    if (rst)          rr_ptr <= '0;
    else if (fill_en) rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
  end

  // R8: fills happen only after a miss, so a page never lives in two slots
  tlb_unique_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));

endmodule

// File: rtl/lpg_mask.sv
module lpg_mask #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] raw_data,
  input  logic              deny,
  output logic [DATA_W-1:0] safe_data
);
  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign safe_data[b] = raw_data[b] & ~deny;
    end
  endgenerate
endmodule

// File: rtl/lpg_ctrl.sv
module lpg_ctrl
  import lpg_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic              req_user,
  input  logic [DATA_W-1:0] req_data,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              flush,
  input  logic              lk_hit,
  input  logic              fill_valid,
  output logic              req_ready,
  output logic              accept,
  output logic              fill_take,
  output logic              walk_req,
  output logic [VPN_W-1:0]  hold_vpn,
  output logic              hold_user,
  output logic [DATA_W-1:0] hold_data,
  output logic [TAG_W-1:0]  hold_tag
);
  lpg_state_e state;
  logic       start_walk;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready && !flush;
  assign start_walk = accept && !lk_hit;
  assign fill_take  = (state == ST_WALK) && fill_valid && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      walk_req <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start_walk) begin
          state    <= ST_WALK;
          walk_req <= 1'b1;
        end
        ST_WALK: if (flush || fill_valid) begin
          state    <= ST_IDLE;
          walk_req <= 1'b0;
        end
        default: begin
          state    <= ST_IDLE;
          walk_req <= 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (start_walk) begin
      hold_vpn  <= req_vpn;
      hold_user <= req_user;
      hold_data <= req_data;
      hold_tag  <= req_tag;
    end
  end

  // R2
  walk_stall_chk: assert property (@(posedge clk) disable iff (rst)
    walk_req |-> !req_ready);

  // R9
  flush_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WALK && flush) |=> (!walk_req && req_ready));

endmodule

// File: rtl/ld_perm_gate.sv
module ld_perm_gate
  import lpg_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int DATA_W  = 64,
  parameter int TAG_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic              req_user,
  input  logic [DATA_W-1:0] req_data,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              flush,
  output logic              walk_req,
  output logic [VPN_W-1:0]  walk_vpn,
  input  logic              fill_valid,
  input  logic              fill_user,
  input  logic              fill_present,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_fault,
  output logic [TAG_W-1:0]  res_tag
);
  logic              lk_hit, lk_user, lk_present;
  logic              accept, fill_take;
  logic [VPN_W-1:0]  hold_vpn;
  logic              hold_user;
  logic [DATA_W-1:0] hold_data;
  logic [TAG_W-1:0]  hold_tag;

  logic              src_user, pg_user, pg_present, deny, done;
  logic [DATA_W-1:0] src_data, safe_data;
  logic [TAG_W-1:0]  src_tag;

  lpg_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_tlb (
    .clk(clk), .rst(rst),
    .lk_vpn(req_vpn), .lk_hit(lk_hit), .lk_user(lk_user), .lk_present(lk_present),
    .fill_en(fill_take), .fill_vpn(hold_vpn),
    .fill_user(fill_user), .fill_present(fill_present)
  );

  lpg_ctrl #(.VPN_W(VPN_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vpn(req_vpn), .req_user(req_user),
    .req_data(req_data), .req_tag(req_tag), .flush(flush),
    .lk_hit(lk_hit), .fill_valid(fill_valid),
    .req_ready(req_ready), .accept(accept), .fill_take(fill_take),
    .walk_req(walk_req), .hold_vpn(hold_vpn), .hold_user(hold_user),
    .hold_data(hold_data), .hold_tag(hold_tag)
  );

  assign walk_vpn = hold_vpn;

  // Source of the completing load: the parked one on a fill, else the live one.
  assign src_user   = fill_take ? hold_user    : req_user;
  assign src_data   = fill_take ? hold_data    : req_data;
  assign src_tag    = fill_take ? hold_tag     : req_tag;
  assign pg_user    = fill_take ? fill_user    : lk_user;
  assign pg_present = fill_take ? fill_present : lk_present;
  assign deny       = lpg_denied(src_user, pg_user, pg_present);
  assign done       = fill_take || (accept && lk_hit);

  lpg_mask #(.DATA_W(DATA_W)) u_mask (
    .raw_data(src_data), .deny(deny), .safe_data(safe_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_fault <= 1'b0;
    end else begin
      res_valid <= done;
      if (done) res_fault <= deny;
    end
  end

  always_ff @(posedge clk) begin
    if (done) begin
      res_data <= safe_data;
      res_tag  <= src_tag;
    end
  end

  // R4
  hit_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && lk_hit) |=> (res_valid && res_tag == $past(req_tag)));

  // R2
  miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !lk_hit) |=> (walk_req && !res_valid && walk_vpn == $past(req_vpn)));

  // R10
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fault) |-> (res_data == '0));

  // R3
  fill_done_chk: assert property (@(posedge clk) disable iff (rst)
    (walk_req && fill_valid && !flush) |=> res_valid);

endmodule

// File: tb/ld_perm_gate_bench.sv
module ld_perm_gate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_vpn = '0;
  logic        req_user = 1'b0;
  logic [63:0] req_data = '0;
  logic [5:0]  req_tag = '0;
  logic        flush = 1'b0;
  logic        walk_req;
  logic [19:0] walk_vpn;
  logic        fill_valid = 1'b0;
  logic        fill_user = 1'b0;
  logic        fill_present = 1'b0;
  logic        res_valid;
  logic [63:0] res_data;
  logic        res_fault;
  logic [5:0]  res_tag;

  int n_chk = 0;
  int n_err = 0;

  logic [63:0] q_data [$];
  logic        q_fault[$];
  logic [5:0]  q_tag  [$];
  string       q_rq   [$];

  always #2 clk = ~clk;

  ld_perm_gate u_ld_perm_gate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_user(req_user), .req_data(req_data), .req_tag(req_tag),
    .flush(flush), .walk_req(walk_req), .walk_vpn(walk_vpn),
    .fill_valid(fill_valid), .fill_user(fill_user), .fill_present(fill_present),
    .res_valid(res_valid), .res_data(res_data), .res_fault(res_fault), .res_tag(res_tag)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic [63:0] d, input bit f, input logic [5:0] tg,
                          input string rq);
    q_data.push_back(f ? 64'h0 : d);
    q_fault.push_back(f);
    q_tag.push_back(tg);
    q_rq.push_back(rq);
  endtask

  // Monitor: compare each result against the scoreboard head.
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (q_data.size() == 0) begin
        chk(1'b0, "R10", "unexpected result tag", {58'h0, res_tag}, 64'h0);
      end else begin
        logic [63:0] ed;
        logic        ef;
        logic [5:0]  et;
        string       er;
        ed = q_data.pop_front();
        ef = q_fault.pop_front();
        et = q_tag.pop_front();
        er = q_rq.pop_front();
        chk(res_tag == et, er, "tag", {58'h0, res_tag}, {58'h0, et});
        chk(res_fault == ef, er, "fault", {63'h0, res_fault}, {63'h0, ef});
        chk(res_data == ed, er, "data", res_data, ed);
      end
    end
  end

  // eu/ep: user and present bits of the page (fill bits on a miss).
  task automatic do_load(input logic [19:0] vpn, input bit usr, input logic [63:0] d,
                         input logic [5:0] tg, input bit miss, input bit eu,
                         input bit ep, input string rq);
    bit f;
    f = !ep || (usr && !eu);
    @(posedge clk); #1;
    if (!miss) push_exp(d, f, tg, rq);
    req_valid = 1'b1; req_vpn = vpn; req_user = usr; req_data = d; req_tag = tg;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (miss) begin
      chk(walk_req && !req_ready, rq, "walk after miss", {63'h0, walk_req}, 64'h1);
      chk(walk_vpn == vpn, rq, "walk page", {44'h0, walk_vpn}, {44'h0, vpn});
    end else begin
      chk(!walk_req && req_ready, rq, "no walk on hit", {63'h0, walk_req}, 64'h0);
    end
    if (walk_req) begin
      repeat (2) @(posedge clk);
      #1;
      if (!miss) push_exp(d, f, tg, rq);
      else push_exp(d, f, tg, rq);
      if (!miss) begin
        q_data.pop_back(); q_fault.pop_back(); q_tag.pop_back(); q_rq.pop_back();
      end
      fill_valid = 1'b1; fill_user = eu; fill_present = ep;
      @(posedge clk); #1;
      fill_valid = 1'b0;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!res_valid, "R1", "res_valid", {63'h0, res_valid}, 64'h0);
    chk(!walk_req, "R1", "walk_req", {63'h0, walk_req}, 64'h0);
    chk(req_ready, "R1", "req_ready", {63'h0, req_ready}, 64'h1);

    // R1 R3: empty cache, user page fill, data passes
    do_load(20'h00010, 1'b1, 64'h1111_2222_3333_4444, 6'd1, 1'b1, 1'b1, 1'b1, "R3");
    // R4 legal hit
    do_load(20'h00010, 1'b1, 64'hCAFE_F00D_0000_0001, 6'd2, 1'b0, 1'b1, 1'b1, "R4");
    // R5 supervisor-only page filled, user load faults
    do_load(20'h00020, 1'b1, 64'hDEAD_BEEF_DEAD_BEEF, 6'd3, 1'b1, 1'b0, 1'b1, "R5");
    do_load(20'h00020, 1'b1, 64'h5555_AAAA_5555_AAAA, 6'd4, 1'b0, 1'b0, 1'b1, "R5");
    // R6 supervisor load passes the same page
    do_load(20'h00020, 1'b0, 64'h0123_4567_89AB_CDEF, 6'd5, 1'b0, 1'b0, 1'b1, "R6");
    // R7 walk finds no mapping, then hits fault too
    do_load(20'h00030, 1'b0, 64'hFFFF_0000_FFFF_0000, 6'd6, 1'b1, 1'b0, 1'b0, "R7");
    do_load(20'h00030, 1'b0, 64'h7777_7777_7777_7777, 6'd7, 1'b0, 1'b0, 1'b0, "R7");

    // R9 flush cancels a walking load; stray fill ignored
    @(posedge clk); #1;
    req_valid = 1'b1; req_vpn = 20'h00040; req_user = 1'b0; req_tag = 6'd8;
    req_data = 64'h9999;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(walk_req, "R9", "walk before flush", {63'h0, walk_req}, 64'h1);
    @(posedge clk); #1;
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
    chk(!walk_req && req_ready, "R9", "walk cleared by flush", {63'h0, walk_req}, 64'h0);
    fill_valid = 1'b1; fill_user = 1'b1; fill_present = 1'b1;
    @(posedge clk); #1;
    fill_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(!walk_req && req_ready, "R9", "idle after stray fill", {63'h0, walk_req}, 64'h0);
    // R9 request with flush high is not accepted (page 0x10 would hit)
    req_valid = 1'b1; req_vpn = 20'h00010; req_user = 1'b0; req_tag = 6'd9;
    flush = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0; flush = 1'b0;
    chk(!walk_req && !res_valid, "R9", "flushed request dropped", {63'h0, res_valid}, 64'h0);
    @(posedge clk); #1;
    // R9 the stray fill installed nothing: page 0x40 still misses
    do_load(20'h00040, 1'b0, 64'h4040_4040, 6'd10, 1'b1, 1'b1, 1'b1, "R9");

    // R8 round-robin: slots 0..3 hold 0x10 0x20 0x30 0x40
    for (int i = 0; i < 4; i++)
      do_load(20'h00100 + 20'(i), 1'b0, 64'(i) + 64'hA0, 6'(11 + i), 1'b1, 1'b1, 1'b1, "R8");
    do_load(20'h00010, 1'b0, 64'hB1, 6'd15, 1'b0, 1'b1, 1'b1, "R8");
    do_load(20'h00104, 1'b0, 64'hB2, 6'd16, 1'b1, 1'b1, 1'b1, "R8");
    do_load(20'h00020, 1'b0, 64'hB3, 6'd17, 1'b0, 1'b0, 1'b1, "R8");
    do_load(20'h00010, 1'b0, 64'hB4, 6'd18, 1'b1, 1'b1, 1'b1, "R8");
    do_load(20'h00020, 1'b1, 64'hB5, 6'd19, 1'b1, 1'b1, 1'b1, "R8");
    do_load(20'h00040, 1'b1, 64'hB6, 6'd20, 1'b0, 1'b1, 1'b1, "R8");

    repeat (4) @(posedge clk);
    #1;
    // R10 every expected result was produced
    chk(q_data.size() == 0, "R10", "missing results", 64'(q_data.size()), 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule